// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block takes a wide vector of level-sensitive interrupt sources and splits it into groups of eight adjacent sources. Each group drives its own output line towards a parent interrupt controller. A group line is high while at least one of its eight sources is both asserted and enabled. Software decides which sources take part, through a small memory-mapped register port with an address, write data, a write strobe and registered read data.

Four groups share one 32-bit register bank, and the banks are spaced 0x10 bytes apart. Each bank has three registers. One turns enables on, one turns enables off, and one reports which enabled sources are currently asserted. Because enables are only ever set or cleared bit by bit, different software contexts can each change their own sources without a read-modify-write sequence. The number of groups is a parameter with a default of 20, which gives 160 sources in five banks.

Top module: `irq_group_merge`

## Requirements
- R1: After a synchronous reset, every enable bit is 0, every group output is low and the read data is 0, whatever the source inputs are.
- R2: A write to bank offset 0x0 sets the enable of each source whose write-data bit is 1. Write-data bits that are 0 leave their enables unchanged.
- R3: A write to bank offset 0x4 clears the enable of each source whose write-data bit is 1. Write-data bits that are 0 leave their enables unchanged.
- R4: A read of bank offset 0x0 or 0x4 returns the bank's current 32-bit enable mask. Read data appears on the clock edge that follows the cycle in which the address is presented.
- R5: A read of bank offset 0xC returns, for each of the bank's 32 sources, the source's input level ANDed with its enable. Source n is bit n%32 of the bank that starts at byte offset (n/32)*0x10.
- R6: Group output g is the OR of status bits 8*(g%4) to 8*(g%4)+7 of bank g/4, that is, of sources 8g to 8g+7. It is registered, so it follows a change of input or enable one clock later.
- R7: Inputs are levels. A group output stays high for as long as an enabled source in the group stays high. It falls one clock after the last such source drops or is disabled.
- R8: Writes to an offset other than 0x0 or 0x4 have no effect on any enable, and reads of such offsets return 0. This covers offset 0x8, unaligned offsets and banks at or above the number of banks. Offset 0xC writes are also ignored.
- R9: With the default of 20 groups, the highest source, 159, is bit 31 of the bank at 0x40 and drives group output 19. The bank at 0x50 does not exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_GROUPS*8 (160) | Level-sensitive interrupt sources |
| reg_addr | input | ADDR_W (12) | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| group_irq | output | NUM_GROUPS (20) | One registered interrupt line per group |

## Verification
The assertions assume that the interrupt inputs are already synchronous to `clk`. The bench meets this by changing `irq_in` only on falling edges. The properties also treat each write as a single-cycle event: they compare the enable state just after a write with the address and data present on the edge where the write was taken. The bench drives every write for exactly one cycle and holds the address and data stable around the rising edge. The enable checks cover whole banks, including partially filled last banks, where enables of sources that do not exist must stay 0.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam logic [3:0] OFS_ENA_ON  = 4'h0;
  localparam logic [3:0] OFS_ENA_OFF = 4'h4;
  localparam logic [3:0] OFS_STATUS  = 4'hC;
  localparam int unsigned BANK_SHIFT = 4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_ON,
    ACC_OFF,
    ACC_STAT
  } acc_e;

  function automatic acc_e decode_ofs(input logic [3:0] ofs);
    case (ofs)
      OFS_ENA_ON:  decode_ofs = ACC_ON;
      OFS_ENA_OFF: decode_ofs = ACC_OFF;
      OFS_STATUS:  decode_ofs = ACC_STAT;
      default:     decode_ofs = ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqm_bank.sv
module irqm_bank #(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned VALID_BITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on_stb,
  input  logic             off_stb,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] src,
  output logic [REG_W-1:0] ena,
  output logic [REG_W-1:0] stat
);
  localparam logic [REG_W-1:0] LIVE_MASK =
    (VALID_BITS >= REG_W) ? {REG_W{1'b1}} : REG_W'((64'd1 << VALID_BITS) - 64'd1);

  logic [REG_W-1:0] ena_q;
  logic [REG_W-1:0] on_bits;
  logic [REG_W-1:0] off_bits;

  assign on_bits  = on_stb  ? wdata : '0;
  assign off_bits = off_stb ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= '0;
    end else begin
      ena_q <= ((ena_q | on_bits) & ~off_bits) & LIVE_MASK;
    end
  end

  assign ena  = ena_q;
  assign stat = src & ena_q;
endmodule

// File: rtl/irqm_group_or.sv
module irqm_group_or #(
  parameter int unsigned GROUP_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GROUP_W-1:0] stat,
  output logic               line
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line <= 1'b0;
    end else begin
      line <= |stat;
    end
  end
endmodule

// File: rtl/irqm_regport.sv
module irqm_regport
  import irqm_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned REG_W     = 32,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       we,
  input  logic [NUM_BANKS*REG_W-1:0] ena_flat,
  input  logic [NUM_BANKS*REG_W-1:0] stat_flat,
  output logic [NUM_BANKS-1:0]       on_stb,
  output logic [NUM_BANKS-1:0]       off_stb,
  output logic [REG_W-1:0]           rdata
);
  localparam int unsigned IDX_W = ADDR_W - BANK_SHIFT;

  logic [IDX_W-1:0]     bank_idx;
  acc_e                 kind;
  logic [NUM_BANKS-1:0] hit;
  logic [REG_W-1:0]     rd_next;

  assign bank_idx = addr[ADDR_W-1:BANK_SHIFT];
  assign kind     = decode_ofs(addr[BANK_SHIFT-1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign hit[b]     = (bank_idx == IDX_W'(b));
    assign on_stb[b]  = we && hit[b] && (kind == ACC_ON);
    assign off_stb[b] = we && hit[b] && (kind == ACC_OFF);
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) begin
        case (kind)
          ACC_ON, ACC_OFF: rd_next = ena_flat[b*REG_W +: REG_W];
          ACC_STAT:        rd_next = stat_flat[b*REG_W +: REG_W];
          default:         rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_next;
    end
  end
endmodule

// File: rtl/irq_group_merge.sv
module irq_group_merge #(
  parameter int unsigned NUM_GROUPS = 20,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned REG_W      = 32,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_GROUPS*GROUP_W-1:0] irq_in,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [REG_W-1:0]              reg_wdata,
  input  logic                          reg_we,
  output logic [REG_W-1:0]              reg_rdata,
  output logic [NUM_GROUPS-1:0]         group_irq
);
  localparam int unsigned GROUPS_PER_BANK = REG_W / GROUP_W;
  localparam int unsigned NUM_SRC   = NUM_GROUPS * GROUP_W;
  localparam int unsigned NUM_BANKS = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
  localparam int unsigned PAD_W     = NUM_BANKS * REG_W;

  logic [PAD_W-1:0]     src_pad;
  logic [PAD_W-1:0]     en_flat;
  logic [PAD_W-1:0]     stat_flat;
  logic [NUM_BANKS-1:0] on_stb;
  logic [NUM_BANKS-1:0] off_stb;

  assign src_pad = PAD_W'(irq_in);

  irqm_regport #(
    .NUM_BANKS(NUM_BANKS),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W)
  ) regport_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .we       (reg_we),
    .ena_flat (en_flat),
    .stat_flat(stat_flat),
    .on_stb   (on_stb),
    .off_stb  (off_stb),
    .rdata    (reg_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LEFT = NUM_SRC - b * REG_W;
    localparam int unsigned VB   = (LEFT > REG_W) ? REG_W : LEFT;
    irqm_bank #(
      .REG_W     (REG_W),
      .VALID_BITS(VB)
    ) bank_i (
      .clk    (clk),
      .rst    (rst),
      .on_stb (on_stb[b]),
      .off_stb(off_stb[b]),
      .wdata  (reg_wdata),
      .src    (src_pad[b*REG_W +: REG_W]),
      .ena    (en_flat[b*REG_W +: REG_W]),
      .stat   (stat_flat[b*REG_W +: REG_W])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    irqm_group_or #(
      .GROUP_W(GROUP_W)
    ) or_i (
      .clk (clk),
      .rst (rst),
      .stat(stat_flat[g*GROUP_W +: GROUP_W]),
      .line(group_irq[g])
    );
  end
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk #(
  parameter int unsigned NUM_GROUPS = 20,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned REG_W      = 32,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_BANKS  = 5
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_GROUPS*GROUP_W-1:0] irq_in,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [REG_W-1:0]              reg_wdata,
  input logic                          reg_we,
  input logic [NUM_GROUPS-1:0]         group_irq,
  input logic [NUM_BANKS*REG_W-1:0]    en_flat
);
  localparam int unsigned NUM_SRC = NUM_GROUPS * GROUP_W;

  logic mapped_wr;
  assign mapped_wr = reg_we
                  && ((reg_addr[3:0] == 4'h0) || (reg_addr[3:0] == 4'h4))
                  && (32'(reg_addr[ADDR_W-1:4]) < NUM_BANKS);

  // R1: state is quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (group_irq == '0 && en_flat == '0));

  // R8: unmapped writes leave all enables unchanged
  p_unmapped_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_we) && !$past(mapped_wr)) |-> $stable(en_flat));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bchk
    localparam int unsigned LEFT = NUM_SRC - b * REG_W;
    localparam int unsigned VB   = (LEFT > REG_W) ? REG_W : LEFT;
    localparam logic [REG_W-1:0] LM =
      (VB >= REG_W) ? {REG_W{1'b1}} : REG_W'((64'd1 << VB) - 64'd1);

    // R2: set bits become 1, other bits hold
    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(reg_we) && $past(reg_addr) == ADDR_W'(b*16))
      |-> (((en_flat[b*REG_W +: REG_W] & $past(reg_wdata)) == ($past(reg_wdata) & LM))
        && ((en_flat[b*REG_W +: REG_W] & ~$past(reg_wdata))
            == ($past(en_flat[b*REG_W +: REG_W]) & ~$past(reg_wdata)))));

    // R3: cleared bits become 0, other bits hold
    p_clear_bits_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(reg_we) && $past(reg_addr) == ADDR_W'(b*16 + 4))
      |-> (((en_flat[b*REG_W +: REG_W] & $past(reg_wdata)) == '0)
        && ((en_flat[b*REG_W +: REG_W] & ~$past(reg_wdata))
            == ($past(en_flat[b*REG_W +: REG_W]) & ~$past(reg_wdata)))));
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_gchk
    // R6: group line follows enabled inputs one cycle later
    p_group_line_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (group_irq[g]
        == |($past(irq_in[g*GROUP_W +: GROUP_W]) & $past(en_flat[g*GROUP_W +: GROUP_W]))));
  end
endmodule

bind irq_group_merge irqm_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .GROUP_W   (GROUP_W),
  .REG_W     (REG_W),
  .ADDR_W    (ADDR_W),
  .NUM_BANKS (NUM_BANKS)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .irq_in   (irq_in),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_we   (reg_we),
  .group_irq(group_irq),
  .en_flat  (en_flat)
);

// File: tb/irq_group_merge_tb_top.sv
`timescale 1ns/1ps
module irq_group_merge_tb_top;
  localparam int NG = 20;
  localparam int NS = NG * 8;
  localparam int NB = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_in = '0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_rdata;
  logic [NG-1:0] group_irq;

  int checks = 0;
  int failures = 0;
  logic [NS-1:0] en_m = '0;

  always #5 clk = ~clk;

  irq_group_merge dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .group_irq(group_irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_groups();
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = |(irq_in[g*8 +: 8] & en_m[g*8 +: 8]);
    return r;
  endfunction

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    int b;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    b = int'(a >> 4);
    if (b < NB && a[3:0] == 4'h0) en_m[b*32 +: 32] = en_m[b*32 +: 32] | d;
    if (b < NB && a[3:0] == 4'h4) en_m[b*32 +: 32] = en_m[b*32 +: 32] & ~d;
  endtask

  task automatic reg_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_inputs(logic [NS-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    irq_in = '1;
    @(negedge clk);
    check("R1 groups", 32'(group_irq), 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    reg_read(12'h000, d); check("R1 enable bank0", d, 32'h0);
    reg_read(12'h00C, d); check("R1 status bank0", d, 32'h0);
    irq_in = '0;
  endtask

  task automatic t_set();
    logic [31:0] d;
    reg_write(12'h010, 32'h0000_00A5);
    reg_read(12'h010, d); check("R2 set A5", d, 32'h0000_00A5);
    reg_read(12'h014, d); check("R4 read via clear offset", d, 32'h0000_00A5);
    reg_write(12'h010, 32'h0000_0100);
    reg_read(12'h010, d); check("R2 zero bits hold", d, 32'h0000_01A5);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    reg_write(12'h014, 32'h0000_0005);
    reg_read(12'h010, d); check("R3 clear", d, 32'h0000_01A0);
    reg_read(12'h000, d); check("R3 other bank untouched", d, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    logic [NS-1:0] v;
    v = '0;
    v[63:32] = 32'hDEAD_BEEF;
    v[31:0]  = 32'hFFFF_FFFF;
    set_inputs(v);
    reg_read(12'h01C, d); check("R5 status bank1", d, 32'hDEAD_BEEF & 32'h0000_01A0);
    reg_read(12'h00C, d); check("R5 status bank0 disabled", d, 32'h0);
  endtask

  task automatic t_group();
    logic [NS-1:0] v;
    v = '0;
    v[32+5] = 1'b1;
    set_inputs(v);
    check("R6 group4 only", 32'(group_irq), 32'(exp_groups()));
    check("R6 group4 high", 32'(group_irq[4]), 32'h1);
    v[32+8] = 1'b1;
    set_inputs(v);
    check("R6 groups4,5", 32'(group_irq), 32'h0000_0030);
    reg_write(12'h000, 32'h8000_0000);
    v[31] = 1'b1;
    set_inputs(v);
    check("R6 group3 added", 32'(group_irq), 32'(exp_groups()));
  endtask

  task automatic t_level();
    logic [NS-1:0] v;
    v = irq_in;
    repeat (3) @(negedge clk);
    check("R7 held high", 32'(group_irq), 32'(exp_groups()));
    v[32+8] = 1'b0;
    set_inputs(v);
    check("R7 drop input", 32'(group_irq[5]), 32'h0);
    reg_write(12'h014, 32'h0000_0020);
    @(negedge clk);
    check("R7 disable while high", 32'(group_irq[4]), 32'h0);
    check("R7 full vector", 32'(group_irq), 32'(exp_groups()));
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    irq_in = '1;
    reg_write(12'h018, 32'hFFFF_FFFF);
    reg_write(12'h011, 32'hFFFF_FFFF);
    reg_write(12'h01C, 32'hFFFF_FFFF);
    reg_write(12'h050, 32'hFFFF_FFFF);
    reg_read(12'h010, d); check("R8 bank1 unchanged", d, 32'h0000_0180);
    reg_read(12'h018, d); check("R8 offset8 reads 0", d, 32'h0);
    reg_read(12'h011, d); check("R8 unaligned reads 0", d, 32'h0);
    reg_read(12'h050, d); check("R8 missing bank reads 0", d, 32'h0);
    check("R8 groups unchanged", 32'(group_irq), 32'(exp_groups()));
  endtask

  task automatic t_top();
    logic [31:0] d;
    logic [NS-1:0] v;
    v = '0;
    set_inputs(v);
    reg_write(12'h040, 32'h8000_0000);
    v[159] = 1'b1;
    set_inputs(v);
    check("R9 group19", 32'(group_irq), 32'h0008_0000);
    reg_read(12'h04C, d); check("R9 status bit31", d, 32'h8000_0000);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set();
    t_clear();
    t_status();
    t_group();
    t_level();
    t_unmapped();
    t_top();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule